// File: doc/BRIEF.md
# Gated Multi-Queue Egress Port

This block is the transmit side of one port of a time-sensitive switch. Each arriving packet carries a signed 16-bit flow identifier, a 3-bit priority and a 2-bit tag that names the ingress port it came in on. The block sorts each packet into one of six descriptor FIFOs: a management queue, four scheduled-traffic queues and a best-effort queue. A drop counter for each queue records packets that arrive at a full queue.

An external gate vector, with one bit for each queue, controls which queues may send. A priority transmitter looks at the heads of the open, non-empty queues and moves one packet into an output register. That register drives a valid/ready interface. Only one packet is in flight at a time. A gate change affects only which packet is chosen next. It never withdraws a packet that has already been presented.

Queue indices are used on `gate_i`, on `out_queue_o` and in the drop counter vector. Index 0 is the management queue. Indices 1 to 4 are the scheduled queues for ingress ports 0 to 3. Index 5 is the best-effort queue.

Top module: `tsn_egress_port`

## Requirements
- R1: A packet whose flow id is negative (two's complement, for example -1 or -300) is stored in queue index 5, whatever its port tag.
- R2: A packet whose flow id is 0 is stored in queue index 0, whatever its port tag.
- R3: A packet whose flow id is positive is stored in queue index 1 + port tag. Tag values 0, 1, 2 and 3 map to indices 1, 2, 3 and 4.
- R4: A packet is taken from queue q only when `gate_i[q]` is 1 at the clock edge where it is selected. When every non-empty queue has its gate at 0, `out_valid_o` stays 0.
- R5: Among the eligible heads, the one with the highest priority value is chosen. On equal priority, the lowest queue index wins.
- R6: While `out_valid_o` is 1 and `out_ready_i` is 0, all output fields stay unchanged on the next cycle.
- R7: Clearing the gate of the queue whose packet is being presented does not lower `out_valid_o`. The packet stays until it is accepted.
- R8: Each queue is first-in first-out and holds 8 descriptors. An arrival at a queue that already holds 8 entries is discarded, and that queue's drop counter increments. The counter saturates and never decreases.
- R9: After reset, `out_valid_o` is 0 and every drop counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Arriving packet valid, one per cycle |
| in_flow_i | input | 16 | Signed flow identifier |
| in_prio_i | input | 3 | Priority, larger value is more urgent |
| in_port_i | input | 2 | Ingress port tag |
| in_data_i | input | DATA_W (32) | Packet descriptor payload |
| gate_i | input | 6 | Gate open bits, one for each queue index |
| out_ready_i | input | 1 | Downstream accepts the presented packet |
| out_valid_o | output | 1 | Packet presented |
| out_flow_o | output | 16 | Flow id of the presented packet |
| out_prio_o | output | 3 | Priority of the presented packet |
| out_data_o | output | DATA_W (32) | Payload of the presented packet |
| out_queue_o | output | 3 | Queue index the packet was taken from |
| drop_cnt_o | output | 48 | Six 8-bit drop counters, queue q at bits [8q+7:8q] |

## Verification
Some properties can be checked on every cycle, and the bound checker covers those:
- Each presented packet's flow id class agrees with the queue index it reports.
- The reporting queue's gate was open at the edge where the packet was selected.
- A stalled output does not move.
- The drop counters never decrease.

Other behaviours depend on the contents of the whole queue set, so only the bench scenarios can show them:
- Priority order with the lowest-index tie-break across several loaded queues.
- First-in first-out order within one queue.
- Discarding the ninth arrival at a full queue.
- The output staying idle while every loaded queue is closed.

// File: rtl/tsn_egress_pkg.sv
package tsn_egress_pkg;
  localparam int NQ     = 6;
  localparam int QIDX_W = 3;
  localparam int FLOW_W = 16;
  localparam int PRIO_W = 3;
  localparam int PORT_W = 2;
  localparam logic [QIDX_W-1:0] Q_MGMT = 3'd0;
  localparam logic [QIDX_W-1:0] Q_ST0  = 3'd1;
  localparam logic [QIDX_W-1:0] Q_BEST = 3'd5;
endpackage

// File: rtl/tsn_classifier.sv
module tsn_classifier
  import tsn_egress_pkg::*;
(
  input  logic [FLOW_W-1:0] flow_i,
  input  logic [PORT_W-1:0] port_i,
  output logic [QIDX_W-1:0] qidx_o
);
  always_comb begin
    if (flow_i[FLOW_W-1])  qidx_o = Q_BEST;
    else if (flow_i == '0) qidx_o = Q_MGMT;
    else                   qidx_o = Q_ST0 + QIDX_W'(port_i);
  end
endmodule

// File: rtl/tsn_desc_fifo.sv
module tsn_desc_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign data_o  = mem_q[rd_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (pop_i)  rd_q <= (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      cnt_q <= cnt_q + CW'(push_i) - CW'(pop_i);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= data_i;
  end
endmodule

// File: rtl/tsn_prio_arb.sv
module tsn_prio_arb
  import tsn_egress_pkg::*;
#(
  parameter int N = NQ
) (
  input  logic [N-1:0]        elig_i,
  input  logic [N*PRIO_W-1:0] prio_i,
  output logic                gnt_valid_o,
  output logic [QIDX_W-1:0]   gnt_idx_o
);
  logic [PRIO_W-1:0] best_prio;

  // strict compare keeps the lowest index on a tie
  always_comb begin
    gnt_valid_o = 1'b0;
    gnt_idx_o   = '0;
    best_prio   = '0;
    for (int i = 0; i < N; i++) begin
      if (elig_i[i] && (!gnt_valid_o || prio_i[i*PRIO_W +: PRIO_W] > best_prio)) begin
        gnt_valid_o = 1'b1;
        gnt_idx_o   = QIDX_W'(i);
        best_prio   = prio_i[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/tsn_egress_port.sv
module tsn_egress_port
  import tsn_egress_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  parameter int CNT_W  = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                in_valid_i,
  input  logic [FLOW_W-1:0]   in_flow_i,
  input  logic [PRIO_W-1:0]   in_prio_i,
  input  logic [PORT_W-1:0]   in_port_i,
  input  logic [DATA_W-1:0]   in_data_i,
  input  logic [NQ-1:0]       gate_i,
  input  logic                out_ready_i,
  output logic                out_valid_o,
  output logic [FLOW_W-1:0]   out_flow_o,
  output logic [PRIO_W-1:0]   out_prio_o,
  output logic [DATA_W-1:0]   out_data_o,
  output logic [QIDX_W-1:0]   out_queue_o,
  output logic [NQ*CNT_W-1:0] drop_cnt_o
);
  localparam int ENT_W = FLOW_W + PRIO_W + DATA_W;

  logic [QIDX_W-1:0]   in_qidx;
  logic [ENT_W-1:0]    in_ent;
  logic [ENT_W-1:0]    head   [NQ];
  logic [NQ-1:0]       empty, full, push, pop, elig;
  logic [NQ*PRIO_W-1:0] head_prio;
  logic                gnt_valid, load;
  logic [QIDX_W-1:0]   gnt_idx;
  logic [ENT_W-1:0]    sel_ent;

  tsn_classifier u_cls (
    .flow_i (in_flow_i),
    .port_i (in_port_i),
    .qidx_o (in_qidx)
  );

  assign in_ent = {in_flow_i, in_prio_i, in_data_i};
  assign elig   = gate_i & ~empty;
  assign load   = !out_valid_o && gnt_valid;

  for (genvar q = 0; q < NQ; q++) begin : g_q
    logic [CNT_W-1:0] drop_q;

    assign push[q] = in_valid_i && (in_qidx == QIDX_W'(q)) && !full[q];
    assign pop[q]  = load && (gnt_idx == QIDX_W'(q));
    assign head_prio[q*PRIO_W +: PRIO_W] = head[q][DATA_W +: PRIO_W];
    assign drop_cnt_o[q*CNT_W +: CNT_W]  = drop_q;

    tsn_desc_fifo #(.W(ENT_W), .DEPTH(DEPTH)) u_fifo (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .push_i  (push[q]),
      .data_i  (in_ent),
      .pop_i   (pop[q]),
      .data_o  (head[q]),
      .empty_o (empty[q]),
      .full_o  (full[q])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) drop_q <= '0;
      else if (in_valid_i && in_qidx == QIDX_W'(q) && full[q] && drop_q != '1)
        drop_q <= drop_q + 1'b1;
    end
  end

  tsn_prio_arb #(.N(NQ)) u_arb (
    .elig_i      (elig),
    .prio_i      (head_prio),
    .gnt_valid_o (gnt_valid),
    .gnt_idx_o   (gnt_idx)
  );

  assign sel_ent = head[gnt_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_flow_o  <= '0;
      out_prio_o  <= '0;
      out_data_o  <= '0;
      out_queue_o <= '0;
    end else if (load) begin
      out_valid_o <= 1'b1;
      {out_flow_o, out_prio_o, out_data_o} <= sel_ent;
      out_queue_o <= gnt_idx;
    end else if (out_valid_o && out_ready_i) begin
      out_valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/tsn_egress_port_chk.sv
module tsn_egress_port_chk
  import tsn_egress_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [NQ-1:0]       gate_i,
  input logic                out_ready_i,
  input logic                out_valid_o,
  input logic [FLOW_W-1:0]   out_flow_o,
  input logic [PRIO_W-1:0]   out_prio_o,
  input logic [DATA_W-1:0]   out_data_o,
  input logic [QIDX_W-1:0]   out_queue_o,
  input logic [NQ*CNT_W-1:0] drop_cnt_o
);
  AST_NEG_TO_BEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_flow_o[FLOW_W-1] |-> out_queue_o == Q_BEST); // R1

  AST_ZERO_TO_MGMT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_flow_o == '0 |-> out_queue_o == Q_MGMT); // R2

  AST_POS_TO_SCHED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_flow_o[FLOW_W-1] && out_flow_o != '0
      |-> out_queue_o >= Q_ST0 && out_queue_o < Q_BEST); // R3

  AST_GATE_OPEN_AT_PICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_valid_o) |-> ((($past(gate_i)) >> out_queue_o) & NQ'(1)) != '0); // R4

  AST_HOLD_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_flow_o) && $stable(out_prio_o)
      && $stable(out_data_o) && $stable(out_queue_o)); // R6

  for (genvar q = 0; q < NQ; q++) begin : g_mono
    AST_DROP_MONOTONIC: assert property (@(posedge clk_i) disable iff (!rst_ni)
      drop_cnt_o[q*CNT_W +: CNT_W] >= $past(drop_cnt_o[q*CNT_W +: CNT_W])); // R8
  end
endmodule

bind tsn_egress_port tsn_egress_port_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .gate_i      (gate_i),
  .out_ready_i (out_ready_i),
  .out_valid_o (out_valid_o),
  .out_flow_o  (out_flow_o),
  .out_prio_o  (out_prio_o),
  .out_data_o  (out_data_o),
  .out_queue_o (out_queue_o),
  .drop_cnt_o  (drop_cnt_o)
);

// File: tb/sim_tsn_egress_port.sv
module sim_tsn_egress_port;
  localparam int DW = 32;

  typedef struct {
    logic [15:0] flow;
    logic [2:0]  prio;
    logic [31:0] data;
    int          stamp;
  } ent_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_flow = '0;
  logic [2:0]  in_prio = '0;
  logic [1:0]  in_port = '0;
  logic [31:0] in_data = '0;
  logic [5:0]  gate = '0;
  logic        out_ready = 1'b0;
  logic        out_valid;
  logic [15:0] out_flow;
  logic [2:0]  out_prio;
  logic [31:0] out_data;
  logic [2:0]  out_queue;
  logic [47:0] drop_cnt;

  int n_chk = 0, n_fail = 0, cyc = 0;
  ent_t mq [6][$];
  int   mdrop [6];
  logic [5:0] gate_e;
  logic       rdy_e;
  logic       pv = 1'b0;
  logic [15:0] hf; logic [2:0] hp; logic [31:0] hd; logic [2:0] hq;
  int out_seen = 0;

  always #4 clk = ~clk;

  tsn_egress_port #(.DATA_W(DW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_flow_i(in_flow),
    .in_prio_i(in_prio), .in_port_i(in_port), .in_data_i(in_data), .gate_i(gate),
    .out_ready_i(out_ready), .out_valid_o(out_valid), .out_flow_o(out_flow),
    .out_prio_o(out_prio), .out_data_o(out_data), .out_queue_o(out_queue),
    .drop_cnt_o(drop_cnt)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic int class_of(input logic [15:0] f, input logic [1:0] p);
    if (f[15]) return 5;
    if (f == 0) return 0;
    return 1 + int'(p);
  endfunction

  always @(posedge clk) begin
    cyc    <= cyc + 1;
    gate_e <= gate;
    rdy_e  <= out_ready;
  end

  // scoreboard push side: follows what the driver presented at each edge
  always @(posedge clk) begin
    if (rst_n && in_valid) begin
      automatic int q = class_of(in_flow, in_port);
      automatic ent_t e;
      e.flow = in_flow; e.prio = in_prio; e.data = in_data; e.stamp = cyc + 1;
      if (mq[q].size() >= 8) begin
        if (mdrop[q] < 255) mdrop[q]++;
      end else mq[q].push_back(e);
    end
  end

  // monitor: on each new presentation, predict the pick and compare
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid && !pv) begin
        automatic int best = -1, n_el = 0;
        automatic logic [2:0] bp = '0;
        for (int q = 0; q < 6; q++)
          if (gate_e[q] && mq[q].size() > 0 && mq[q][0].stamp < cyc) begin
            n_el++;
            if (best < 0 || mq[q][0].prio > bp) begin best = q; bp = mq[q][0].prio; end
          end
        out_seen++;
        if (best < 0) check(1'b0, "R4", "unexpected packet from queue", out_queue, 7);
        else begin
          automatic ent_t e = mq[best].pop_front();
          automatic string tag = (n_el > 1) ? "R5" : (best == 0) ? "R2" : (best == 5) ? "R1" : "R3";
          check(out_queue == 3'(best), tag, "queue", out_queue, best);
          check(out_data == e.data && out_flow == e.flow && out_prio == e.prio, "R8",
                "head payload", out_data, e.data);
        end
      end
      if (pv && !rdy_e)
        check(out_valid && out_flow == hf && out_prio == hp && out_data == hd && out_queue == hq,
              "R6", "stalled output changed", out_data, hd);
      pv = out_valid; hf = out_flow; hp = out_prio; hd = out_data; hq = out_queue;
    end
  end

  task automatic send(input logic [15:0] f, input logic [2:0] p, input logic [1:0] pt,
                      input logic [31:0] d);
    @(posedge clk); #2;
    in_valid = 1'b1; in_flow = f; in_prio = p; in_port = pt; in_data = d;
  endtask

  task automatic stop_in();
    @(posedge clk); #2;
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  function automatic int total_left();
    int t = 0;
    for (int q = 0; q < 6; q++) t += mq[q].size();
    return t;
  endfunction

  bit done = 1'b0;

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      check(1'b0, "R9", "watchdog expired", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int q = 0; q < 6; q++) mdrop[q] = 0;
    idle(3);
    @(negedge clk);
    check(out_valid == 1'b0, "R9", "valid in reset", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0 && drop_cnt == '0, "R9", "state after reset", drop_cnt, 0);

    // classification, all gates open
    gate = 6'h3f; out_ready = 1'b1;
    send(16'hffff, 3'd1, 2'd2, 32'h1001);  // R1
    stop_in(); idle(4);
    send(16'hfed4, 3'd4, 2'd0, 32'h1002);  // R1 with -300
    stop_in(); idle(4);
    send(16'h0000, 3'd0, 2'd3, 32'h1003);  // R2
    stop_in(); idle(4);
    for (int p = 0; p < 4; p++) begin      // R3
      send(16'd7 + 16'(p), 3'd2, 2'(p), 32'h2000 + 32'(p));
      stop_in(); idle(4);
    end
    check(out_seen == 7 && total_left() == 0, "R3", "classified packets drained", out_seen, 7);

    // priority and tie order (R5), FIFO order (R8)
    gate = '0; out_ready = 1'b0;
    send(16'd10, 3'd2, 2'd0, 32'h3001);
    send(16'd11, 3'd5, 2'd1, 32'h3002);
    send(16'd12, 3'd5, 2'd0, 32'h3003);
    send(16'd0,  3'd5, 2'd0, 32'h3004);
    send(16'hffff, 3'd7, 2'd0, 32'h3005);
    stop_in(); idle(3);
    check(out_valid == 1'b0, "R4", "closed gates keep output idle", out_valid, 0);
    gate = 6'h3f; out_ready = 1'b1;
    idle(20);
    check(out_seen == 12 && total_left() == 0, "R5", "priority drain complete", out_seen, 12);

    // partial gating (R4)
    gate = 6'b000100; out_ready = 1'b1;
    send(16'd20, 3'd6, 2'd0, 32'h4001);
    send(16'd21, 3'd1, 2'd1, 32'h4002);
    stop_in(); idle(8);
    check(out_seen == 13 && out_valid == 1'b0, "R4", "only open queue sent", out_seen, 13);
    check(mq[1].size() == 1, "R4", "gated queue kept its packet", mq[1].size(), 1);
    gate = 6'b000110; idle(6);
    check(out_seen == 14, "R4", "reopened queue sent", out_seen, 14);

    // stall and gate close while presenting (R6, R7)
    out_ready = 1'b0; gate = 6'h3f;
    send(16'd0, 3'd3, 2'd0, 32'h5001);
    stop_in(); idle(3);
    gate = '0;
    idle(6);
    @(negedge clk);
    check(out_valid == 1'b1 && out_data == 32'h5001, "R7", "gate close kept packet", out_data, 32'h5001);
    @(posedge clk); #2;
    out_ready = 1'b1; gate = 6'h3f;
    idle(4);
    check(out_seen == 15 && out_valid == 1'b0, "R6", "stalled packet accepted", out_seen, 15);

    // overflow of best-effort queue (R8)
    gate = '0; out_ready = 1'b0;
    for (int i = 0; i < 10; i++) send(16'hffff, 3'(i), 2'd0, 32'h6000 + 32'(i));
    stop_in(); idle(2);
    @(negedge clk);
    check(drop_cnt[5*8 +: 8] == 8'd2, "R8", "drop count after overflow", drop_cnt[5*8 +: 8], 2);
    check(drop_cnt[39:0] == '0, "R8", "other drop counters untouched", drop_cnt[39:0], 0);
    @(posedge clk); #2;
    gate = 6'h3f; out_ready = 1'b1;
    idle(30);
    check(out_seen == 23 && total_left() == 0, "R8", "eight survivors drained", out_seen, 23);
    check(drop_cnt[5*8 +: 8] == 8'(mdrop[5]), "R8", "drop count matches model", drop_cnt[5*8 +: 8], mdrop[5]);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule